// File: doc/BRIEF.md
# Binary Extension Field Multiplier (Horner Form, Interleaved Reduction)

This block multiplies two elements of GF(2^M), each held as an M-bit vector of polynomial coefficients with the X^(M-1) coefficient in the most significant bit. It walks the first operand from its top coefficient down to its lowest. On each step it shifts the partial result up by one place, adds the second operand when the current coefficient of the first operand is set, and subtracts the field polynomial when a bit leaves the top of the partial result. Reduction therefore happens inside the loop, and no double-width product is ever formed.

Two build options shape the block. `ITERATIVE` picks a sequential datapath with a single step circuit that needs M-1 cycles after loading, or an unrolled chain of M-1 step circuits that returns the result on the clock edge that accepts `start`. `FIXED_POLY` picks where the field polynomial comes from. It either comes in on a port with each operation, or it is a constant parameter that synthesis folds into the XOR network, which gives a smaller and faster circuit. Outputs are registered. `done` pulses for one cycle when `product` holds a new result.

Top module: `gf2m_horner_mul`

## Requirements
- R1: `product` equals op_a·op_b reduced modulo the field polynomial. The polynomial is M+1 bits wide with the X^M coefficient at bit M, and operand and result bit k is the coefficient of X^k.
- R2: With M=5 and field polynomial 6'b101111, op_a=5'b10110 times op_b=5'b10010 gives 5'b11011.
- R3: When either operand is zero, the product is zero.
- R4: When either operand is 1 (only bit 0 set), the product equals the other operand.
- R5: In the port-polynomial build, the polynomial is captured together with the operands when `start` is accepted. Changes on `field_poly` after that do not affect the result of the operation in progress.
- R6: In the fixed-polynomial build, `field_poly` has no effect on `product`.
- R7: In the iterative build, `done` rises exactly M-1 clock edges after the edge that accepted `start`. In the unrolled build, it rises on the accepting edge itself.
- R8: `done` is high for one cycle per operation, and `product` does not change except on an edge that raises `done`.
- R9: In the iterative build, `start`, operand changes and polynomial changes during an operation are ignored.
- R10: After reset, `product` is zero and `done` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request a multiplication of the present operands |
| op_a | input | M | First operand, consumed from its top coefficient down |
| op_b | input | M | Second operand |
| field_poly | input | M+1 | Field polynomial, bit M is the X^M coefficient; unused in the fixed build |
| product | output | M | Registered result |
| done | output | 1 | One-cycle strobe marking a new result |

## Verification
The assertions assume that `field_poly` has bit M set whenever `start` is high in the port-polynomial build. The bench therefore forces that bit to one on every polynomial it drives to a port-polynomial instance, and drives arbitrary patterns only to fixed-polynomial instances. The iterative checks also assume that `start` may stay high through a running operation. The bench does exactly this in its disturbance runs, so that the ignored requests fall inside the window the busy-hold property watches.

// File: rtl/gfm_pkg.sv
`timescale 1ns/1ps
package gfm_pkg;

  typedef enum logic {
    GFM_IDLE = 1'b0,
    GFM_RUN  = 1'b1
  } gfm_state_e;

  // width of a down-counter that indexes coefficients 0 .. m-2
  function automatic int gfm_idx_w(input int m);
    return (m <= 2) ? 1 : $clog2(m);
  endfunction

endpackage

// File: rtl/gfm_horner_step.sv
`timescale 1ns/1ps
module gfm_horner_step #(
  parameter int M = 8
) (
  input  logic [M-1:0] acc,
  input  logic [M-1:0] mcand,
  input  logic [M-1:0] red,
  input  logic         bit_in,
  output logic [M-1:0] nxt
);

  // one Horner step: multiply by X, fold the escaping bit, add mcand
  always_comb begin
    nxt = {acc[M-2:0], 1'b0}
        ^ (mcand & {M{bit_in}})
        ^ (red   & {M{acc[M-1]}});
  end

endmodule

// File: rtl/gfm_poly_src.sv
`timescale 1ns/1ps
module gfm_poly_src #(
  parameter int         M     = 8,
  parameter bit         FIXED = 1'b0,
  parameter logic [M:0] POLY  = '0
) (
  input  logic [M:0]   poly_in,
  output logic [M-1:0] red
);

  // only the low M coefficients take part in folding; X^M is implied
  generate
    if (FIXED) begin : g_fixed
      logic unused_poly;
      assign unused_poly = ^poly_in;
      assign red         = POLY[M-1:0];
    end else begin : g_port
      logic unused_top;
      assign unused_top = poly_in[M];
      assign red        = poly_in[M-1:0];
    end
  endgenerate

endmodule

// File: rtl/gfm_iter_core.sv
`timescale 1ns/1ps
module gfm_iter_core
  import gfm_pkg::*;
#(
  parameter int M = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [M-1:0] a,
  input  logic [M-1:0] b,
  input  logic [M-1:0] red,
  output logic [M-1:0] product,
  output logic         done
);

  localparam int            IW      = gfm_idx_w(M);
  localparam logic [IW-1:0] IDX_TOP = IW'(M - 2);

  gfm_state_e    state;
  logic [M-1:0]  a_q, b_q, red_q, acc, acc_nxt;
  logic [IW-1:0] idx;

  gfm_horner_step #(.M(M)) u_step (
    .acc   (acc),
    .mcand (b_q),
    .red   (red_q),
    .bit_in(a_q[idx]),
    .nxt   (acc_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= GFM_IDLE;
      a_q     <= '0;
      b_q     <= '0;
      red_q   <= '0;
      acc     <= '0;
      idx     <= '0;
      product <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        GFM_IDLE: begin
          if (start) begin
            a_q   <= a;
            b_q   <= b;
            red_q <= red;
            acc   <= b & {M{a[M-1]}};
            idx   <= IDX_TOP;
            state <= GFM_RUN;
          end
        end
        GFM_RUN: begin
          if (idx == '0) begin
            product <= acc_nxt;
            done    <= 1'b1;
            state   <= GFM_IDLE;
          end else begin
            acc <= acc_nxt;
            idx <= idx - 1'b1;
          end
        end
        default: state <= GFM_IDLE;
      endcase
    end
  end

  // cycle counter used only by the latency check
  int lat_q;
  always_ff @(posedge clk) begin
    if (rst)                             lat_q <= 0;
    else if (state == GFM_IDLE && start) lat_q <= 0;
    else if (state == GFM_RUN)           lat_q <= lat_q + 1;
  end

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R7
  iter_latency_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (lat_q == M - 1));

  // R9
  busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (state == GFM_RUN) |=> ($stable(a_q) && $stable(b_q) && $stable(red_q)));

endmodule

// File: rtl/gfm_comb_core.sv
`timescale 1ns/1ps
module gfm_comb_core #(
  parameter int M = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [M-1:0] a,
  input  logic [M-1:0] b,
  input  logic [M-1:0] red,
  output logic [M-1:0] product,
  output logic         done
);

  logic [M-1:0] stage [M];

  assign stage[0] = b & {M{a[M-1]}};

  generate
    for (genvar i = 1; i < M; i++) begin : g_chain
      gfm_horner_step #(.M(M)) u_step (
        .acc   (stage[i-1]),
        .mcand (b),
        .red   (red),
        .bit_in(a[M-1-i]),
        .nxt   (stage[i])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      product <= '0;
      done    <= 1'b0;
    end else begin
      done <= start;
      if (start) product <= stage[M-1];
    end
  end

  // R7
  comb_done_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(start));

  // R3
  zero_operand_chk: assert property (@(posedge clk) disable iff (rst)
    (start && (a == '0 || b == '0)) |=> (product == '0));

endmodule

// File: rtl/gf2m_horner_mul.sv
`timescale 1ns/1ps
module gf2m_horner_mul #(
  parameter int         M          = 8,
  parameter bit         ITERATIVE  = 1'b1,
  parameter bit         FIXED_POLY = 1'b0,
  parameter logic [M:0] POLY       = 9'h11B
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [M-1:0] op_a,
  input  logic [M-1:0] op_b,
  input  logic [M:0]   field_poly,
  output logic [M-1:0] product,
  output logic         done
);

  logic [M-1:0] red;

  gfm_poly_src #(.M(M), .FIXED(FIXED_POLY), .POLY(POLY)) u_poly (
    .poly_in(field_poly),
    .red    (red)
  );

  generate
    if (ITERATIVE) begin : g_iter
      gfm_iter_core #(.M(M)) u_core (
        .clk(clk), .rst(rst), .start(start),
        .a(op_a), .b(op_b), .red(red),
        .product(product), .done(done)
      );
    end else begin : g_comb
      gfm_comb_core #(.M(M)) u_core (
        .clk(clk), .rst(rst), .start(start),
        .a(op_a), .b(op_b), .red(red),
        .product(product), .done(done)
      );
    end

    if (!FIXED_POLY) begin : g_poly_chk
      // R5
      poly_monic_chk: assert property (@(posedge clk) disable iff (rst)
        start |-> field_poly[M]);
    end
  endgenerate

  // R8
  product_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(product));

endmodule

// File: tb/tb_gf2m_horner_mul.sv
`timescale 1ns/1ps
module gfm_harness #(
  parameter int         M     = 5,
  parameter bit         ITER  = 1'b1,
  parameter bit         FIXED = 1'b0,
  parameter logic [M:0] POLY  = '0,
  parameter int         SEED  = 1
) (
  input  logic clk,
  input  logic rst,
  output logic fin,
  output int   runs,
  output int   fails
);

  logic         start;
  logic [M-1:0] a, b, product, last;
  logic [M:0]   fp;
  logic         done;

  gf2m_horner_mul #(.M(M), .ITERATIVE(ITER), .FIXED_POLY(FIXED), .POLY(POLY)) dut (
    .clk(clk), .rst(rst), .start(start), .op_a(a), .op_b(b),
    .field_poly(fp), .product(product), .done(done)
  );

  // schoolbook carry-less product, then long division by q
  function automatic logic [M-1:0] ref_mul(input logic [M-1:0] x, input logic [M-1:0] y,
                                           input logic [M:0] q);
    logic [2*M-1:0] wide;
    wide = '0;
    for (int i = 0; i < M; i++)
      if (y[i]) wide = wide ^ ((2*M)'(x) << i);
    for (int i = 2*M-2; i >= M; i--)
      if (wide[i]) wide = wide ^ ((2*M)'(q) << (i - M));
    return wide[M-1:0];
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    runs++;
    if (!ok) begin
      fails++;
      $display("FAIL %s (M=%0d): actual %0h expected %0h", req, M, act, exp);
    end
  endtask

  task automatic scramble();
    a  = M'($urandom);
    b  = M'($urandom);
    fp = {1'b1, M'($urandom)};
  endtask

  task automatic run_op(input logic [M-1:0] x, input logic [M-1:0] y, input bit pol_given,
                        input logic [M:0] pol, input string req, input bit disturb);
    logic [M:0]   p_used;
    logic [M-1:0] expv, held;
    int           lat, exp_lat;
    string        tag;
    p_used  = FIXED ? POLY : (pol_given ? pol : {1'b1, M'($urandom)});
    exp_lat = ITER ? M - 1 : 0;
    expv    = ref_mul(x, y, p_used);
    tag     = FIXED ? {req, " R6"} : req;
    a = x; b = y; start = 1'b1;
    fp = FIXED ? (M+1)'($urandom) : p_used;
    @(negedge clk);
    lat = 0;
    if (ITER && disturb) scramble();
    else start = 1'b0;
    while (!done && lat < M + 4) begin
      @(negedge clk);
      lat++;
      if (ITER && disturb && !done) scramble();
    end
    start = 1'b0;
    chk(done == 1'b1, "R7 done raised", 32'(done), 1);
    chk(lat == exp_lat, "R7 latency", 32'(lat), 32'(exp_lat));
    chk(product == expv, tag, 32'(product), 32'(expv));
    last = product;
    held = product;
    @(negedge clk);
    chk(done == 1'b0, "R8 done single cycle", 32'(done), 0);
    chk(product == held, "R8 product held", 32'(product), 32'(held));
  endtask

  initial begin
    logic [M-1:0] r;
    fin = 1'b0; runs = 0; fails = 0;
    start = 1'b0; a = '0; b = '0; fp = '0; last = '0;
    void'($urandom(SEED));
    @(negedge clk);
    while (rst) @(negedge clk);
    chk(product == '0, "R10 reset product", 32'(product), 0);
    chk(done == 1'b0, "R10 reset done", 32'(done), 0);

    if (M == 5) begin
      run_op(M'(5'b10110), M'(5'b10010), 1'b1, (M+1)'(6'b101111), "R1 R2 known vector", 1'b0);
      chk(last == M'(5'b11011), "R2 fixed value", 32'(last), 32'h1B);
    end

    r = M'($urandom) | M'(1);
    run_op('0, r, 1'b0, '0, "R3 zero first", 1'b0);
    chk(last == '0, "R3 zero first value", 32'(last), 0);
    run_op(r, '0, 1'b0, '0, "R3 zero second", 1'b1);
    chk(last == '0, "R3 zero second value", 32'(last), 0);

    r = M'($urandom);
    run_op(M'(1), r, 1'b0, '0, "R4 unit first", 1'b1);
    chk(last == r, "R4 unit first value", 32'(last), 32'(r));
    run_op(r, M'(1), 1'b0, '0, "R4 unit second", 1'b0);
    chk(last == r, "R4 unit second value", 32'(last), 32'(r));

    run_op('1, '1, 1'b0, '0, "R1 all ones", 1'b0);
    run_op(M'(1) << (M-1), M'(1) << (M-1), 1'b0, '0, "R1 top coefficient", 1'b1);

    for (int i = 0; i < 24; i++) begin
      run_op(M'($urandom), M'($urandom), 1'b0, '0,
             i[0] ? "R1 R5 R9 random disturbed" : "R1 random", i[0]);
    end
    fin = 1'b1;
  end

endmodule

module tb_gf2m_horner_mul;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic f5, f8, f8r, f11;
  int   n5, n8, n8r, n11, e5, e8, e8r, e11;

  gfm_harness #(.M(5),  .ITER(1'b1), .FIXED(1'b0), .POLY(6'b101111),  .SEED(11)) h5 (
    .clk(clk), .rst(rst), .fin(f5),  .runs(n5),  .fails(e5));
  gfm_harness #(.M(8),  .ITER(1'b0), .FIXED(1'b1), .POLY(9'h11B),     .SEED(23)) h8 (
    .clk(clk), .rst(rst), .fin(f8),  .runs(n8),  .fails(e8));
  gfm_harness #(.M(8),  .ITER(1'b0), .FIXED(1'b0), .POLY(9'h11D),     .SEED(37)) h8r (
    .clk(clk), .rst(rst), .fin(f8r), .runs(n8r), .fails(e8r));
  gfm_harness #(.M(11), .ITER(1'b1), .FIXED(1'b1), .POLY(12'h805),    .SEED(41)) h11 (
    .clk(clk), .rst(rst), .fin(f11), .runs(n11), .fails(e11));

  initial begin
    int cyc, total, bad;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    cyc = 0;
    while (!(f5 && f8 && f8r && f11) && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    total = n5 + n8 + n8r + n11;
    bad   = e5 + e8 + e8r + e11;
    if (!(f5 && f8 && f8r && f11)) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
    end
    $display("[TB] %0d tests run, %0d failed", total, bad);
    $finish;
  end

endmodule